// File: doc/BRIEF.md
# Filtered Input Transition Detector

This block watches a small general-purpose input port. All seven input lines are brought into the clock domain through a synchronizer, and the CPU can read them directly through a read port. Bit 7 of that read always returns 1. The four low lines also feed transition filters. These filters take samples only when a slow sampling tick is high. The tick is supplied from outside and is typically near 38.4 kHz, which gives a sample period a little over 25 µs. A new level is accepted only when two consecutive samples agree on it.

Each accepted transition sets a bit in a change register. Both rising and falling transitions set the bit. The bit stays set until the CPU reads the change register. That read returns the bits as they were before the read, then clears them. A transition that is accepted in the same cycle as the clearing read stays recorded. The change register also reports the current filtered level of the four lines in its upper nibble. An interrupt mask chooses which change bits can raise the interrupt request.

Top module: `pin_delta_watch`

## Requirements
- R1: After reset the four filtered levels are 1, every change bit is 0, and `irq_o` is low. The change read therefore returns 8'hF0.
- R2: A read with `rd_sel_i`=0 returns {1'b1, pins_i[6:0]}, where the pin value is the one present two rising clock edges earlier. Bit 7 is always 1.
- R3: A line's filtered level moves only on a cycle with `sample_tick_i` high, and only when the current sample and the previous sample both differ from the filtered level. A change seen on a single sample is discarded.
- R4: A rising or a falling filtered transition on line n (n = 0..3) sets change bit n. The change read (`rd_sel_i`=1) returns {level[3:0], change[3:0]}, with the filtered level in bits 7:4 and the change bits in bits 3:0.
- R5: Change bits stay set across any number of cycles. A change read returns the bits in the same cycle, and they are zero from the next clock edge.
- R6: If a transition is accepted in the same cycle as a change read, its bit is set after that edge. The read itself returns the value from before the transition.
- R7: `irq_o` is high exactly when some change bit is set and its bit in `irq_mask_i` is 1. Masked bits do not raise it.
- R8: A raw read (`rd_sel_i`=0) leaves the change bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pins_i | input | 7 | Asynchronous input lines |
| sample_tick_i | input | 1 | One-cycle slow sampling enable |
| rd_i | input | 1 | CPU read strobe |
| rd_sel_i | input | 1 | 0 = raw port, 1 = change register |
| irq_mask_i | input | 4 | Interrupt enable per change bit |
| rd_data_o | output | 8 | Read data, valid in the cycle of the strobe |
| irq_o | output | 1 | Interrupt request |

## Verification
A pin value reaches the raw read after two rising edges. The bench therefore drives the pins on a falling edge and compares on the falling edge that follows the second rising edge. A filtered transition appears at the edge that closes the second agreeing tick cycle, and `irq_o` follows in the same cycle. The bench waits three clocks after each pin change before it issues any tick, and checks one falling edge after the tick cycle. Read data is combinational and is compared one nanosecond after the strobe is raised. The effect of the clear is checked on the next read.

// File: rtl/pdw_pkg.sv
package pdw_pkg;
  // A new level is taken when the present and the previous sample agree on it and it differs from the held level.
  function automatic logic accept_edge(input logic smp_now, input logic smp_prev,
                                       input logic held);
    return (smp_now == smp_prev) && (smp_now != held);
  endfunction

  // Sticky change bits: clear on request, but new events always win.
  function automatic logic [3:0] next_delta(input logic [3:0] cur, input logic clr,
                                            input logic [3:0] evt);
    return (clr ? 4'b0 : cur) | evt;
  endfunction
endpackage

// File: rtl/pdw_sync.sv
module pdw_sync #(
  parameter int W      = 7,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '1;
      else if (s == 0) stg[s] <= d_i;
      else stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/pdw_filter.sv
module pdw_filter
  import pdw_pkg::*;
#(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic [N-1:0] smp_i,
  output logic [N-1:0] level_o,
  output logic [N-1:0] evt_o
);
  for (genvar n = 0; n < N; n++) begin : g_line
    logic prev_q, lvl_q;
    assign evt_o[n]   = tick_i && accept_edge(smp_i[n], prev_q, lvl_q);
    assign level_o[n] = lvl_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q <= 1'b1;
        lvl_q  <= 1'b1;
      end else if (tick_i) begin
        prev_q <= smp_i[n];
        if (evt_o[n]) lvl_q <= smp_i[n];
      end
    end
  end
endmodule

// File: rtl/pdw_delta_reg.sv
module pdw_delta_reg
  import pdw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_i,
  input  logic [3:0] evt_i,
  output logic [3:0] delta_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) delta_o <= '0;
    else delta_o <= next_delta(delta_o, clr_i, evt_i);
  end
endmodule

// File: rtl/pin_delta_watch.sv
module pin_delta_watch #(
  parameter int RAW_W       = 7,
  parameter int DET_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RAW_W-1:0] pins_i,
  input  logic             sample_tick_i,
  input  logic             rd_i,
  input  logic             rd_sel_i,
  input  logic [DET_W-1:0] irq_mask_i,
  output logic [RAW_W:0]   rd_data_o,
  output logic             irq_o
);
  localparam int RD_W = RAW_W + 1;

  logic [RAW_W-1:0] raw_sync;
  logic [DET_W-1:0] level_q, change_evt, delta_q;
  logic             clr_rd;

  assign clr_rd = rd_i && rd_sel_i;

  pdw_sync #(.W(RAW_W), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d_i(pins_i), .q_o(raw_sync));

  pdw_filter #(.N(DET_W)) filt_i (
    .clk(clk), .rst_n(rst_n), .tick_i(sample_tick_i),
    .smp_i(raw_sync[DET_W-1:0]), .level_o(level_q), .evt_o(change_evt));

  pdw_delta_reg dreg_i (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_rd), .evt_i(change_evt), .delta_o(delta_q));

  assign rd_data_o = rd_sel_i ? RD_W'({level_q, delta_q}) : {1'b1, raw_sync};
  assign irq_o     = |(delta_q & irq_mask_i);
endmodule

// File: rtl/pdw_checker.sv
module pdw_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       sample_tick_i,
  input logic       rd_i,
  input logic       rd_sel_i,
  input logic [3:0] irq_mask_i,
  input logic [7:0] rd_data_o,
  input logic       irq_o,
  input logic [3:0] delta_q,
  input logic [3:0] level_q,
  input logic [3:0] change_evt
);
  p_level_needs_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_tick_i |=> $stable(level_q));

  p_delta_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_i && rd_sel_i) |=> ((delta_q & $past(delta_q)) == $past(delta_q)));

  p_evt_not_lost_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|change_evt) |=> ((delta_q & $past(change_evt)) == $past(change_evt)));

  p_evt_moves_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|change_evt) |=> ((level_q ^ $past(level_q)) == $past(change_evt)));

  p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mask_i == 4'b0) |-> !irq_o);

  p_raw_msb_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_sel_i |-> rd_data_o[7]);
endmodule

bind pin_delta_watch pdw_checker chk_i (
  .clk(clk), .rst_n(rst_n), .sample_tick_i(sample_tick_i), .rd_i(rd_i),
  .rd_sel_i(rd_sel_i), .irq_mask_i(irq_mask_i), .rd_data_o(rd_data_o),
  .irq_o(irq_o), .delta_q(delta_q), .level_q(level_q), .change_evt(change_evt));

// File: tb/pin_delta_watch_tb_top.sv
module pin_delta_watch_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] pins = 7'h7F;
  logic       tick = 1'b0, rd = 1'b0, sel = 1'b0;
  logic [3:0] mask = 4'h0;
  logic [7:0] rd_data;
  logic       irq;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  pin_delta_watch dut_i (
    .clk(clk), .rst_n(rst_n), .pins_i(pins), .sample_tick_i(tick), .rd_i(rd),
    .rd_sel_i(sel), .irq_mask_i(mask), .rd_data_o(rd_data), .irq_o(irq));

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_tick();
    tick = 1'b1;
    @(posedge clk); @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic do_read(input logic s, input logic with_tick, output logic [7:0] val);
    rd = 1'b1; sel = s; tick = with_tick;
    #1 val = rd_data;
    @(posedge clk); @(negedge clk);
    rd = 1'b0; sel = 1'b0; tick = 1'b0;
  endtask

  function automatic logic [7:0] chg_word(input logic [3:0] lvl, input logic [3:0] d);
    return {lvl, d};
  endfunction

  initial begin
    logic [7:0] v;
    logic [3:0] lvl_m;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    mask = 4'hF;
    // R1 reset state
    chk({7'b0, irq}, 8'h00, "R1");
    do_read(1'b1, 1'b0, v);
    chk(v, 8'hF0, "R1");

    // R2 raw port sweep
    for (int p = 0; p < 128; p++) begin
      pins = p[6:0];
      @(posedge clk); @(posedge clk); @(negedge clk);
      sel = 1'b0; #1;
      chk(rd_data, {1'b1, p[6:0]}, "R2");
    end
    pins = 7'h7F;
    settle();

    // R3/R4/R5 each line, each direction
    lvl_m = 4'hF;
    for (int n = 0; n < 4; n++) begin
      for (int dir = 0; dir < 2; dir++) begin
        pins[n] = dir[0];
        settle();
        do_tick();
        chk({7'b0, irq}, 8'h00, "R3");
        do_tick();
        lvl_m[n] = dir[0];
        chk({7'b0, irq}, 8'h01, "R7");
        do_read(1'b1, 1'b0, v);
        chk(v, chg_word(lvl_m, 4'(1 << n)), "R4");
        do_read(1'b1, 1'b0, v);
        chk(v, chg_word(lvl_m, 4'h0), "R5");
      end
    end

    // R3 single-sample glitch discarded
    pins[2] = 1'b0; settle(); do_tick();
    pins[2] = 1'b1; settle(); do_tick(); do_tick();
    do_read(1'b1, 1'b0, v);
    chk(v, 8'hF0, "R3");

    // R5/R8 sticky across idle and raw reads
    pins[1] = 1'b0; settle(); do_tick(); do_tick();
    repeat (50) @(negedge clk);
    chk({7'b0, irq}, 8'h01, "R5");
    do_read(1'b0, 1'b0, v);
    chk(v, 8'hFD, "R8");
    do_read(1'b1, 1'b0, v);
    chk(v, 8'hD2, "R8");
    pins[1] = 1'b1; settle(); do_tick(); do_tick();
    do_read(1'b1, 1'b0, v);

    // R6 change coincident with clearing read
    pins[3] = 1'b0; settle(); do_tick();
    do_read(1'b1, 1'b1, v);
    chk(v, 8'hF0, "R6");
    do_read(1'b1, 1'b0, v);
    chk(v, 8'h78, "R6");
    pins[3] = 1'b1; settle(); do_tick(); do_tick();
    do_read(1'b1, 1'b0, v);

    // R7 masking
    pins[0] = 1'b0; settle(); do_tick(); do_tick();
    mask = 4'b1110; #1;
    chk({7'b0, irq}, 8'h00, "R7");
    mask = 4'b0001; #1;
    chk({7'b0, irq}, 8'h01, "R7");
    do_read(1'b1, 1'b0, v);
    chk(v, 8'hE1, "R7");
    #1 chk({7'b0, irq}, 8'h00, "R7");

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule